// File: doc/BRIEF.md
# Real-time clock tick prescaler

This block turns a slow reference clock into the timing events that a real-time clock needs. The reference arrives as a one-cycle tick enable in the system clock domain. A 2-bit rate-select input says which of three reference frequencies is fitted. A fractional divider first produces a 512 Hz base event. A binary chain driven by that base event then produces a 1 Hz event and nine periodic events from 2 Hz to 512 Hz.

Every event is a single system-clock pulse. The events are given both as separate outputs and as a 16-bit vector whose bit positions match the interrupt status layout that follows this block. The 1 Hz event is the one that advances the seconds count downstream. When the enable input is low, the whole block is held cleared. Rate select is meant to be changed only while enable is low.

Top module: `rtc_tick_gen`

## Requirements
- R1: While reset is asserted, `sec_tick`, `per_tick` and `evt_vec` are all zero.
- R2: With rate_sel = 2'b00 (32768 Hz reference), the 512 Hz event fires once every 64 reference ticks, which gives 512 base events and exactly one `sec_tick` in 32768 reference ticks.
- R3: With rate_sel = 2'b01 (32000 Hz reference), 32000 reference ticks give exactly 512 base events and one `sec_tick`.
- R4: With rate_sel = 2'b10 (38400 Hz reference), the base event fires once every 75 reference ticks, which gives 512 base events and one `sec_tick` in 38400 reference ticks.
- R5: With rate_sel = 2'b01, the base period alternates between 62 and 63 reference ticks. The first period after enable is 62 ticks, so the average is 62.5.
- R6: rate_sel = 2'b11 behaves exactly like 2'b00 (period of 64 reference ticks).
- R7: While `en` is low, no event is emitted from the next clock onward and all divider state is cleared. After `en` rises, the first base event needs a full divisor of reference ticks.
- R8: `per_tick[i]` runs at 2^(i+1) Hz: index 0 is 2 Hz and index 8 is 512 Hz. It fires on every 2^(8-i)-th base event, counted from enable, and `sec_tick` fires on every 512th base event.
- R9: Every event output is high for exactly one system-clock cycle per occurrence.
- R10: Rates are phase-aligned. When `per_tick[i]` fires, every faster `per_tick[j]` (j > i) fires in the same cycle, and `sec_tick` fires only together with `per_tick[0]`.
- R11: `evt_vec` bit 4 is the 1 Hz event, bit 7 is 2 Hz, and bits 8 to 15 are 4 Hz to 512 Hz in ascending order. All other bits are zero.
- R12: Only cycles with `ref_tick` high advance the divider. The base event appears on the outputs two clocks after the clock edge that samples the reference tick completing the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable; low clears all state |
| rate_sel | input | 2 | Reference frequency code (00 32768 Hz, 01 32000 Hz, 10 38400 Hz, 11 as 00) |
| ref_tick | input | 1 | One-cycle enable per reference clock period |
| sec_tick | output | 1 | 1 Hz event pulse |
| per_tick | output | 9 | Periodic event pulses, bit i at 2^(i+1) Hz |
| evt_vec | output | 16 | Events placed at their status-register bit positions |

## Verification
A behavioural model predicts every output on every cycle from a running count of reference ticks. It does not track a divider counter: it compares that count against the closed-form boundaries 64n, 75n and floor(125n/2).

Each of the three codes runs for one full second with a reference tick on every cycle. This separates a divider that is right on average from one that only happens to land on 512 events. The 32000 Hz run also checks the order of the 62 and 63 periods. The reserved code is run and compared against the 64-tick period.

A sparse reference (one tick every third cycle) separates counting reference ticks from counting clocks. Dropping enable in the middle of a period separates a true clear from a hold of state.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

    typedef enum logic [1:0] {
        SEL_32768 = 2'b00,
        SEL_32000 = 2'b01,
        SEL_38400 = 2'b10,
        SEL_RSVD  = 2'b11
    } rate_sel_e;

    localparam int EVT_W       = 16;
    localparam int EVT_SEC_BIT = 4;
    localparam int EVT_PER_LSB = 7;

endpackage

// File: rtl/rtc_ref_divider.sv
module rtc_ref_divider
    import rtc_tick_pkg::*;
#(
    parameter int DIV_STD     = 64,
    parameter int DIV_FRAC_LO = 62,
    parameter int DIV_FRAC_HI = 63,
    parameter int DIV_WIDE    = 75
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       ref_tick,
    input  logic [1:0] rate_sel,
    output logic       base_tick
);
    localparam int MAX_A  = (DIV_STD > DIV_WIDE) ? DIV_STD : DIV_WIDE;
    localparam int MAX_D  = (MAX_A > DIV_FRAC_HI) ? MAX_A : DIV_FRAC_HI;
    localparam int CNT_W  = $clog2(MAX_D);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
        logic             base;
    } div_st_t;

    div_st_t q, d;
    logic [CNT_W-1:0] last;

    always_comb begin
        case (rate_sel_e'(rate_sel))
            SEL_32000: last = q.phase ? CNT_W'(DIV_FRAC_HI - 1) : CNT_W'(DIV_FRAC_LO - 1);
            SEL_38400: last = CNT_W'(DIV_WIDE - 1);
            default:   last = CNT_W'(DIV_STD - 1);
        endcase

        d = q;
        if (!en) begin
            d = '0;
        end else begin
            d.base = 1'b0;
            if (ref_tick) begin
                if (q.cnt == last) begin
                    d.cnt   = '0;
                    d.base  = 1'b1;
                    d.phase = ~q.phase;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign base_tick = q.base;

endmodule

// File: rtl/rtc_rate_chain.sv
module rtc_rate_chain #(
    parameter int N_PER = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             base_tick,
    output logic [N_PER-1:0] per_tick,
    output logic             sec_tick
);
    typedef struct packed {
        logic [N_PER-1:0] chain;
        logic [N_PER-1:0] per;
        logic             sec;
    } chain_st_t;

    chain_st_t q, d;

    always_comb begin
        logic [N_PER-1:0] mask;
        mask = '0;
        d = q;
        if (!en) begin
            d = '0;
        end else begin
            d.per = '0;
            d.sec = 1'b0;
            if (base_tick) begin
                d.chain = q.chain + 1'b1;
                for (int i = 0; i < N_PER; i++) begin
                    mask     = N_PER'((1 << (N_PER - 1 - i)) - 1);
                    d.per[i] = ((q.chain & mask) == mask);
                end
                d.sec = &q.chain;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign per_tick = q.per;
    assign sec_tick = q.sec;

endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen
    import rtc_tick_pkg::*;
#(
    parameter int N_PER       = 9,
    parameter int DIV_STD     = 64,
    parameter int DIV_FRAC_LO = 62,
    parameter int DIV_FRAC_HI = 63,
    parameter int DIV_WIDE    = 75
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       rate_sel,
    input  logic             ref_tick,
    output logic             sec_tick,
    output logic [N_PER-1:0] per_tick,
    output logic [EVT_W-1:0] evt_vec
);
    logic base_tick;

    rtc_ref_divider #(
        .DIV_STD     (DIV_STD),
        .DIV_FRAC_LO (DIV_FRAC_LO),
        .DIV_FRAC_HI (DIV_FRAC_HI),
        .DIV_WIDE    (DIV_WIDE)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .ref_tick  (ref_tick),
        .rate_sel  (rate_sel),
        .base_tick (base_tick)
    );

    rtc_rate_chain #(
        .N_PER (N_PER)
    ) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .base_tick (base_tick),
        .per_tick  (per_tick),
        .sec_tick  (sec_tick)
    );

    always_comb begin
        evt_vec = '0;
        evt_vec[EVT_SEC_BIT] = sec_tick;
        for (int i = 0; i < N_PER; i++) begin
            evt_vec[EVT_PER_LSB + i] = per_tick[i];
        end
    end

endmodule

// File: rtl/rtc_tick_chk.sv
module rtc_tick_chk #(
    parameter int N_PER = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             ref_tick,
    input logic             sec_tick,
    input logic [N_PER-1:0] per_tick
);
    // R9
    fast_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick[N_PER-1] |=> !per_tick[N_PER-1]);

    // R9
    sec_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    // R10
    sec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> per_tick[0]);

    generate
        for (genvar i = 0; i < N_PER - 1; i++) begin : g_align
            // R10
            rate_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
                per_tick[i] |-> per_tick[i+1]);
        end
    endgenerate

    // R7
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (per_tick == '0 && !sec_tick));

    // R12
    ref_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick[N_PER-1] |-> $past(ref_tick, 2));

endmodule

bind rtc_tick_gen rtc_tick_chk #(.N_PER(N_PER)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .ref_tick (ref_tick),
    .sec_tick (sec_tick),
    .per_tick (per_tick)
);

// File: tb/sim_rtc_tick_gen.sv
`timescale 1ns/1ps
module sim_rtc_tick_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  rate_sel = 2'b00;
    logic        ref_tick = 1'b0;
    logic        sec_tick;
    logic [8:0]  per_tick;
    logic [15:0] evt_vec;

    always #2.5 clk = ~clk;

    rtc_tick_gen u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .rate_sel(rate_sel),
        .ref_tick(ref_tick), .sec_tick(sec_tick), .per_tick(per_tick),
        .evt_vec(evt_vec)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // behavioural reference: count reference ticks, compare with closed-form period boundaries
    int         refc = 0;
    int         nb = 0;
    logic [8:0] pend = '0;
    logic       pend_sec = 1'b0;
    logic [8:0] e_per = '0;
    logic       e_sec = 1'b0;

    function automatic int bound(input logic [1:0] sel, input int n);
        if (sel == 2'b01)      return (125 * n) / 2;
        else if (sel == 2'b10) return 75 * n;
        else                   return 64 * n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n || !en) begin
            refc = 0; nb = 0; pend = '0; pend_sec = 1'b0;
            e_per = '0; e_sec = 1'b0;
        end else begin
            e_per = pend; e_sec = pend_sec;
            pend = '0; pend_sec = 1'b0;
            if (ref_tick) begin
                refc++;
                if (refc == bound(rate_sel, nb + 1)) begin
                    nb++;
                    for (int i = 0; i < 9; i++) pend[i] = ((nb % (1 << (8 - i))) == 0);
                    pend_sec = ((nb % 512) == 0);
                end
            end
        end
    end

    int   pcnt [9];
    int   scnt = 0;
    int   b4cnt = 0;
    int   ts [$];
    int   dbl = 0;
    int   misalign = 0;
    logic prev512 = 1'b0;
    logic prevsec = 1'b0;

    always @(negedge clk) begin
        logic [15:0] exp_evt;
        cyc++;
        if (rst_n) begin
            exp_evt = '0;
            exp_evt[4] = e_sec;
            exp_evt[15:7] = e_per;
            total++;
            if (per_tick !== e_per || sec_tick !== e_sec || evt_vec !== exp_evt) begin
                bad++;
                $display("FAIL R8/R11 cycle %0d per act=%b exp=%b sec act=%b exp=%b evt act=%h exp=%h",
                         cyc, per_tick, e_per, sec_tick, e_sec, evt_vec, exp_evt);
            end
            for (int i = 0; i < 9; i++) if (per_tick[i]) pcnt[i]++;
            if (sec_tick) scnt++;
            if (evt_vec[4]) b4cnt++;
            if (per_tick[8]) ts.push_back(cyc);
            if ((per_tick[8] && prev512) || (sec_tick && prevsec)) dbl++;
            if (sec_tick && per_tick != 9'h1ff) misalign++;
            for (int i = 0; i < 8; i++) if (per_tick[i] && !per_tick[i+1]) misalign++;
            prev512 = per_tick[8];
            prevsec = sec_tick;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        for (int i = 0; i < 9; i++) pcnt[i] = 0;
        scnt = 0; b4cnt = 0;
        ts.delete();
    endtask

    task automatic step(input logic r);
        @(negedge clk);
        ref_tick = r;
    endtask

    task automatic run(input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            step(1'b1);
            for (int g = 0; g < gap; g++) step(1'b0);
        end
        for (int k = 0; k < 4; k++) step(1'b0);
    endtask

    task automatic stop_block();
        @(negedge clk);
        en = 1'b0;
        for (int k = 0; k < 3; k++) step(1'b0);
    endtask

    task automatic one_second(input logic [1:0] sel, input int refs, input string tag);
        @(negedge clk);
        rate_sel = sel; en = 1'b1;
        clear_counts();
        run(refs, 0);
        chk({tag, " 512Hz count"}, pcnt[8], 512);
        chk({tag, " 1Hz count"}, scnt, 1);
        for (int i = 0; i < 8; i++) chk("R8 rate count", pcnt[i], 1 << (i + 1));
        chk("R11 evt bit4 count", b4cnt, 1);
        stop_block();
    endtask

    initial begin
        #(190000 * 5);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 9; i++) pcnt[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 per_tick in reset", int'(per_tick), 0);
        chk("R1 sec_tick in reset", int'(sec_tick), 0);
        chk("R1 evt_vec in reset", int'(evt_vec), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7 disabled: reference ticks give no events
        clear_counts();
        run(200, 0);
        chk("R7 no events while disabled", pcnt[8] + scnt, 0);

        one_second(2'b00, 32768, "R2");
        one_second(2'b01, 32000, "R3");
        one_second(2'b10, 38400, "R4");

        // R5 alternating periods
        @(negedge clk);
        rate_sel = 2'b01; en = 1'b1;
        clear_counts();
        run(250, 0);
        chk("R5 first to second period", ts[1] - ts[0], 63);
        chk("R5 second to third period", ts[2] - ts[1], 62);
        chk("R5 base count in 250 ticks", pcnt[8], 4);
        stop_block();

        // R6 reserved code
        @(negedge clk);
        rate_sel = 2'b11; en = 1'b1;
        clear_counts();
        run(640, 0);
        chk("R6 base count", pcnt[8], 10);
        chk("R6 period", ts[1] - ts[0], 64);
        stop_block();

        // R7 enable drop mid-period clears state
        @(negedge clk);
        rate_sel = 2'b00; en = 1'b1;
        clear_counts();
        run(40, 0);
        chk("R7 partial period silent", pcnt[8], 0);
        @(negedge clk);
        en = 1'b0;
        for (int k = 0; k < 5; k++) step(1'b1);
        @(negedge clk);
        en = 1'b1; ref_tick = 1'b0;
        clear_counts();
        run(63, 0);
        chk("R7 restart needs full divisor", pcnt[8], 0);
        run(1, 0);
        chk("R7 first base after restart", pcnt[8], 1);
        stop_block();

        // R12 sparse reference ticks
        @(negedge clk);
        rate_sel = 2'b00; en = 1'b1;
        clear_counts();
        run(128, 2);
        chk("R12 sparse base count", pcnt[8], 2);
        chk("R12 sparse period in clocks", ts[1] - ts[0], 192);
        stop_block();

        chk("R9 no wide pulses", dbl, 0);
        chk("R10 alignment violations", misalign, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule